// File: doc/BRIEF.md
# Serial Register Access Controller

This block is the slave end of a three-wire serial link (serial clock, data in, data out, plus an active-low select) that lets a host reach a small bank of internal registers. It is always waiting for a one-byte command first. That command names a target register and a direction. The transfer that follows is then routed to that register. Three byte-wide registers can be written and read back. One of them is a test-control byte whose non-zero value raises a test-mode flag. A fourth, 16-bit slot shows the latest conversion word supplied by the surrounding logic. That slot can only be read.

A write aimed at the read-only slot is still honoured as a 16-bit transfer, and its payload is thrown away, so the host and the block stay aligned. A host that has lost track of where the interface is can send a long run of one bits to bring it back to the command-waiting state. Dropping the select line has the same effect mid-transfer. All logic runs on the serial clock. Input bits are taken on its rising edge and output bits are launched on its falling edge.

Top module: `serial_reg_port`

## Requirements
- R1: While `rstN` is low, `testMode` and `sdout` are 0. After reset all three byte registers read back 0.
- R2: When idle, the block treats the next 8 rising-edge bits (MSB first) as a command byte. Bit 7 must be 0. Bits [5:4] select the target: 00 and 01 are general byte registers, 10 is the test byte, 11 is the 16-bit conversion slot. Bit 3 is 1 for a read and 0 for a write. Bits 6 and 2..0 are don't-care.
- R3: A write command to a byte register takes the next 8 bits MSB first and stores them at the 8th rising edge. The interface is then idle again.
- R4: After a read command, `sdout` presents the selected value MSB first. Each bit changes on a falling edge, with the first bit launched on the falling edge after the command's last rising edge. The transfer is 8 bits for byte registers and 16 bits for the conversion slot, and the interface is idle afterwards.
- R5: A read of the conversion slot returns `convData` as sampled on the command's last rising edge. Later changes of `convData` do not alter the word being shifted out.
- R6: A write command to the conversion slot consumes exactly 16 following bits, discards them, alters no register, and then returns to idle.
- R7: `testMode` is 1 exactly when the test byte holds a non-zero value.
- R8: 32 consecutive 1 bits on `sdin` return the interface to idle from any state and any bit position. The run itself stores nothing into the test byte.
- R9: Raising `csN` during a transfer aborts it without storing anything, and the interface is idle when `csN` falls again.
- R10: A command byte whose bit 7 is 1 is ignored in full, and the interface waits for the next command byte.
- R11: `sdout` is 0 whenever no read transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; rising edge samples, falling edge launches |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select; high forces the interface idle |
| sdin | input | 1 | Serial data from the host, MSB first |
| convData | input | 16 | Latest conversion result exposed through the read-only slot |
| sdout | output | 1 | Serial data to the host, MSB first |
| testMode | output | 1 | High while the test byte is non-zero |

## Verification
A stored byte lands on the 8th rising edge of its payload, so `testMode` is checked after that edge's clock period ends, never inside it. Read bits come one per falling edge. The first bit follows the falling edge after the command's last rising edge, and each next bit follows the falling edge after the rising edge that consumed the previous one. The bench therefore drives `sdin` and samples `sdout` a quarter period after each falling edge, before the next rising edge. Every collected read word goes to a scoreboard that compares it in order against the value the driver predicted.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int BYTE_W        = 8;
  localparam int WORD_W        = 16;
  localparam int RESYNC_LEN    = 32;
  localparam int NUM_BYTE_REGS = 3;
  localparam int SEL_W         = 2;
  localparam int CNT_W         = $clog2(WORD_W);
  localparam int ONES_W        = $clog2(RESYNC_LEN + 1);

  // command byte layout
  localparam int CMD_START_BIT = 7;
  localparam int CMD_SEL_LSB   = 4;
  localparam int CMD_READ_BIT  = 3;

  localparam logic [SEL_W-1:0] SEL_TEST = 2'b10;
  localparam logic [SEL_W-1:0] SEL_DATA = 2'b11;

  typedef enum logic [1:0] {PH_IDLE, PH_WRITE, PH_READ} phaseT;

  typedef struct packed {
    logic             loadShadow;
    logic             shiftOut;
    logic             commit;
    logic [SEL_W-1:0] sel;
  } strobeT;
endpackage

// File: rtl/sra_ctrl.sv
module sra_ctrl
  import sra_pkg::*;
(
  input  logic              sclk,
  input  logic              ctlRst,
  input  logic              sdin,
  input  logic [BYTE_W-1:0] nextByte,
  output phaseT             phase,
  output strobeT            stb
);
  localparam logic [CNT_W-1:0]  BYTE_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0]  WORD_LAST = CNT_W'(WORD_W - 1);
  localparam logic [ONES_W-1:0] ONES_LAST = ONES_W'(RESYNC_LEN - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [ONES_W-1:0] onesCnt;
  logic [SEL_W-1:0]  selR;
  logic              lastBit, resync, cmdValid, cmdRead;
  logic              unusedCmdBits;

  assign unusedCmdBits = ^nextByte;
  assign resync   = sdin && (onesCnt == ONES_LAST);
  assign cmdValid = !nextByte[CMD_START_BIT];
  assign cmdRead  = nextByte[CMD_READ_BIT];

  // transfer length depends on the latched target outside the command phase
  always_comb begin
    if (phase != PH_IDLE && selR == SEL_DATA) lastBit = (bitCnt == WORD_LAST);
    else                                      lastBit = (bitCnt == BYTE_LAST);
  end

  always_comb begin
    stb     = '0;
    stb.sel = selR;
    if (!resync) begin
      case (phase)
        PH_IDLE: if (lastBit && cmdValid) begin
          stb.sel        = nextByte[CMD_SEL_LSB +: SEL_W];
          stb.loadShadow = cmdRead;
        end
        PH_WRITE: stb.commit   = lastBit && (selR != SEL_DATA);
        PH_READ:  stb.shiftOut = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge sclk or posedge ctlRst) begin
    if (ctlRst) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      onesCnt <= '0;
      selR    <= '0;
    end else begin
      if (!sdin || resync) onesCnt <= '0;
      else                 onesCnt <= onesCnt + ONES_W'(1);

      if (resync) begin
        phase  <= PH_IDLE;
        bitCnt <= '0;
      end else if (lastBit) begin
        bitCnt <= '0;
        if (phase == PH_IDLE) begin
          if (cmdValid) begin
            selR  <= nextByte[CMD_SEL_LSB +: SEL_W];
            phase <= cmdRead ? PH_READ : PH_WRITE;
          end
        end else begin
          phase <= PH_IDLE;
        end
      end else begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sra_dpath.sv
module sra_dpath
  import sra_pkg::*;
(
  input  logic              sclk,
  input  logic              rstN,
  input  logic              ctlRst,
  input  logic              sdin,
  input  logic [WORD_W-1:0] convData,
  input  phaseT             phase,
  input  strobeT            stb,
  output logic [BYTE_W-1:0] nextByte,
  output logic              sdout,
  output logic              testMode
);
  logic [BYTE_W-2:0] inShift;
  logic [NUM_BYTE_REGS-1:0][BYTE_W-1:0] byteRegs;
  logic [BYTE_W-1:0] readByte;
  logic [WORD_W-1:0] shadow;
  logic              outBit;

  assign nextByte = {inShift, sdin};

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) inShift <= '0;
    else       inShift <= nextByte[BYTE_W-2:0];
  end

  for (genvar i = 0; i < NUM_BYTE_REGS; i++) begin : gByteReg
    always_ff @(posedge sclk or negedge rstN) begin
      if (!rstN)                                  byteRegs[i] <= '0;
      else if (stb.commit && stb.sel == SEL_W'(i)) byteRegs[i] <= nextByte;
    end
  end

  always_comb begin
    readByte = '0;
    for (int i = 0; i < NUM_BYTE_REGS; i++)
      if (stb.sel == SEL_W'(i)) readByte = byteRegs[i];
  end

  // snapshot at the command's last edge keeps the outgoing word stable
  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) shadow <= '0;
    else if (stb.loadShadow)
      shadow <= (stb.sel == SEL_DATA) ? convData : {readByte, {(WORD_W-BYTE_W){1'b0}}};
    else if (stb.shiftOut)
      shadow <= {shadow[WORD_W-2:0], 1'b0};
  end

  always_ff @(negedge sclk or posedge ctlRst) begin
    if (ctlRst) outBit <= 1'b0;
    else        outBit <= (phase == PH_READ) ? shadow[WORD_W-1] : 1'b0;
  end

  assign sdout    = outBit;
  assign testMode = |byteRegs[SEL_TEST];
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import sra_pkg::*;
(
  input  logic              sclk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sdin,
  input  logic [WORD_W-1:0] convData,
  output logic              sdout,
  output logic              testMode
);
  logic              ctlRst;
  logic [BYTE_W-1:0] nextByte;
  phaseT             phase;
  strobeT            stb;

  assign ctlRst = !rstN || csN;

  sra_ctrl ctrlInst (
    .sclk     (sclk),
    .ctlRst   (ctlRst),
    .sdin     (sdin),
    .nextByte (nextByte),
    .phase    (phase),
    .stb      (stb)
  );

  sra_dpath dpathInst (
    .sclk     (sclk),
    .rstN     (rstN),
    .ctlRst   (ctlRst),
    .sdin     (sdin),
    .convData (convData),
    .phase    (phase),
    .stb      (stb),
    .nextByte (nextByte),
    .sdout    (sdout),
    .testMode (testMode)
  );
endmodule

// File: rtl/sra_chk.sv
module sra_chk
  import sra_pkg::*;
(
  input logic  sclk,
  input logic  rstN,
  input logic  csN,
  input logic  sdin,
  input logic  sdout,
  input logic  testMode,
  input phaseT phase
);
  localparam logic [ONES_W-1:0] ONES_LAST = ONES_W'(RESYNC_LEN - 1);

  logic              chkRst;
  logic [ONES_W-1:0] onesRun;
  logic              resyncPrev;
  phaseT             prevPhase;
  logic [CNT_W:0]    wrCnt;

  assign chkRst = !rstN || csN;

  always_ff @(posedge sclk or posedge chkRst) begin
    if (chkRst) begin
      onesRun    <= '0;
      resyncPrev <= 1'b0;
      prevPhase  <= PH_IDLE;
      wrCnt      <= '0;
    end else begin
      resyncPrev <= sdin && (onesRun == ONES_LAST);
      if (!sdin || onesRun == ONES_LAST) onesRun <= '0;
      else                               onesRun <= onesRun + ONES_W'(1);
      prevPhase <= phase;
      wrCnt     <= (phase == PH_WRITE) ? wrCnt + (CNT_W+1)'(1) : '0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(negedge sclk) !rstN |-> (!testMode && !sdout));

  // R11
  idle_out_chk: assert property (@(posedge sclk) disable iff (chkRst)
    (phase == PH_IDLE) |-> !sdout);

  // R8
  resync_chk: assert property (@(posedge sclk) disable iff (chkRst)
    resyncPrev |-> (phase == PH_IDLE));

  // R6
  write_len_chk: assert property (@(posedge sclk) disable iff (chkRst)
    (prevPhase == PH_WRITE && phase == PH_IDLE && !resyncPrev)
      |-> (wrCnt == (CNT_W+1)'(BYTE_W) || wrCnt == (CNT_W+1)'(WORD_W)));

  // R7
  testmode_src_chk: assert property (@(posedge sclk) disable iff (chkRst)
    (testMode != $past(testMode)) |-> (prevPhase == PH_WRITE));
endmodule

bind serial_reg_port sra_chk chkInst (
  .sclk     (sclk),
  .rstN     (rstN),
  .csN      (csN),
  .sdin     (sdin),
  .sdout    (sdout),
  .testMode (testMode),
  .phase    (phase)
);

// File: tb/tb_serial_reg_port.sv
module tb_serial_reg_port;
  localparam int CLK_PERIOD = 10;

  logic        sclk = 1'b0, rstN = 1'b0, csN = 1'b1, sdin = 1'b0;
  logic [15:0] convData = '0;
  logic        sdout, testMode;

  int checks = 0, errors = 0;
  bit done = 0, quietBad = 0;
  logic [15:0] expQ[$], gotQ[$];
  string       tagQ[$];

  serial_reg_port dut (
    .sclk(sclk), .rstN(rstN), .csN(csN), .sdin(sdin),
    .convData(convData), .sdout(sdout), .testMode(testMode)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bit: drive, sample a quarter period later, rising then falling edge
  task automatic tick(input logic d, output logic q);
    sdin = d;
    #(CLK_PERIOD/4);
    q = sdout;
    #(CLK_PERIOD/4);
    sclk = 1'b1;
    #(CLK_PERIOD/2);
    sclk = 1'b0;
  endtask

  task automatic sendBits(input logic [15:0] v, input int n, input bit watch);
    logic q;
    for (int i = n - 1; i >= 0; i--) begin
      tick(v[i], q);
      if (watch && q) quietBad = 1;
    end
  endtask

  function automatic logic [7:0] cmd(input logic [1:0] sel, input logic rd);
    return {2'b00, sel, rd, 3'b000};
  endfunction

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] v);
    sendBits(16'(cmd(sel, 1'b0)), 8, 1);
    sendBits(16'(v), 8, 1);
  endtask

  // driver: predicts the word, then collects it for the monitor
  task automatic readReg(input string tag, input logic [1:0] sel, input int n,
                         input logic [15:0] exp);
    logic [15:0] w = '0;
    logic q;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    sendBits(16'(cmd(sel, 1'b1)), 8, 1);
    for (int i = 0; i < n; i++) begin
      tick(1'b0, q);
      w = {w[14:0], q};
    end
    gotQ.push_back(w);
  endtask

  initial begin : monitor
    forever begin
      wait (gotQ.size() > 0);
      check(tagQ.pop_front(), gotQ.pop_front(), expQ.pop_front());
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stimulus
    logic q;
    // R1 reset state
    for (int i = 0; i < 2; i++) tick(1'b0, q);
    check("R1 testMode in reset", 16'(testMode), 16'h0);
    check("R1 sdout in reset", 16'(sdout), 16'h0);
    rstN = 1'b1;
    #(CLK_PERIOD);
    csN = 1'b0;
    readReg("R1 test byte after reset", 2'b10, 8, 16'h00);
    readReg("R1 byte0 after reset", 2'b00, 8, 16'h00);

    // R2 R3 write and read back
    writeReg(2'b00, 8'hA5);
    writeReg(2'b01, 8'h3C);
    readReg("R3 byte0 readback", 2'b00, 8, 16'hA5);
    readReg("R2 byte1 readback", 2'b01, 8, 16'h3C);

    // R7 test flag
    writeReg(2'b10, 8'h01);
    check("R7 testMode after 0x01", 16'(testMode), 16'h1);
    writeReg(2'b10, 8'h80);
    check("R7 testMode after 0x80", 16'(testMode), 16'h1);
    readReg("R4 test byte readback", 2'b10, 8, 16'h80);
    writeReg(2'b10, 8'h00);
    check("R7 testMode after clear", 16'(testMode), 16'h0);

    // R5 R4 conversion word snapshot
    convData = 16'hBEEF;
    expQ.push_back(16'hBEEF);
    tagQ.push_back("R5 snapshot held during shift");
    sendBits(16'(cmd(2'b11, 1'b1)), 8, 1);
    convData = 16'h1234;
    begin
      logic [15:0] w = '0;
      for (int i = 0; i < 16; i++) begin tick(1'b0, q); w = {w[14:0], q}; end
      gotQ.push_back(w);
    end
    readReg("R4 second conversion read", 2'b11, 16, 16'h1234);

    // R6 write to read-only slot is 16 discarded bits
    sendBits(16'(cmd(2'b11, 1'b0)), 8, 1);
    sendBits({cmd(2'b10, 1'b0), 8'hFF}, 16, 1);
    check("R6 testMode after discarded write", 16'(testMode), 16'h0);
    readReg("R6 idle after discarded write", 2'b00, 8, 16'hA5);

    // R10 command with bit 7 set is ignored
    sendBits(16'h0098, 8, 1);
    readReg("R10 next command honoured", 2'b01, 8, 16'h3C);

    // R8 resync from inside a discarded write
    sendBits(16'(cmd(2'b11, 1'b0)), 8, 1);
    sendBits(16'h0000, 4, 1);
    for (int i = 0; i < 32; i++) tick(1'b1, q);
    check("R8 testMode after run of ones", 16'(testMode), 16'h0);
    readReg("R8 aligned after resync (write)", 2'b00, 8, 16'hA5);

    // R8 resync from inside a read
    sendBits(16'(cmd(2'b11, 1'b1)), 8, 1);
    for (int i = 0; i < 5; i++) tick(1'b0, q);
    for (int i = 0; i < 32; i++) tick(1'b1, q);
    readReg("R8 aligned after resync (read)", 2'b01, 8, 16'h3C);

    // R9 select abort
    sendBits(16'(cmd(2'b10, 1'b0)), 8, 1);
    sendBits(16'h000A, 4, 1);
    csN = 1'b1;
    #(CLK_PERIOD);
    check("R9 sdout with select high", 16'(sdout), 16'h0);
    csN = 1'b0;
    #(CLK_PERIOD);
    check("R9 testMode after abort", 16'(testMode), 16'h0);
    readReg("R9 test byte after abort", 2'b10, 8, 16'h00);
    readReg("R9 aligned after abort", 2'b00, 8, 16'hA5);
    check("R9 testMode after realign", 16'(testMode), 16'h0);

    // R11 quiet output outside reads
    check("R11 sdout low outside reads", 16'(quietBad), 16'h0);

    #(CLK_PERIOD);
    wait (gotQ.size() == 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule